// File: doc/BRIEF.md
# Reorderable 24-Channel LED Shift and Latch Path

This block is the digital front end of a 24-channel LED sink driver. The channels form three colour groups of eight: red, green and blue. A serial bit stream is clocked into a 24-bit shift chain. The chain links the three group registers in an order that is picked at run time by a 2-bit flow select. A storage register takes a copy of the chain while the latch input is high. Each colour group then reaches the channel outputs through its own active-low enable. The last stage of the chain drives a serial output, so several blocks can be chained in a cascade.

For fault reporting, a load strobe writes a 24-bit word of per-channel status into the chain in a single cycle. The status then leaves on the serial output as the chain shifts. It comes out in the same group order that the flow select sets for incoming data.

Top module: `led_shift_latch`

## Requirements
- R1: After reset the shift chain and the storage register are all zero, so `chanOut` and `serOut` are 0.
- R2: `flowSel` picks the group order from the serial input towards the serial output: 2'b11 gives B, G, R; 2'b01 gives B, R, G; 2'b10 gives R, G, B; 2'b00 gives G, R, B. A board ties `flowSel` high by default, which gives B, G, R. Channel fields are fixed: `chanOut[7:0]` is red, `[15:8]` is green and `[23:16]` is blue. Inside a group, the incoming bit enters bit 0 and leaves from bit 7. After 24 shifts of a word W, sent MSB first, the first group holds W[7:0], the middle group holds W[15:8] and the last group holds W[23:16].
- R3: `serOut` is bit 7 of the last group. A bit that is shifted in appears on `serOut` after exactly 24 shifts.
- R4: While `latchEn` is high, the storage register takes the chain's updated value at every clock edge.
- R5: While `latchEn` is low, the storage register holds its value, even while the chain shifts.
- R6: When enable bit `grpEnN[g]` is high (g=0 red, 1 green, 2 blue), the eight outputs of group g are 0. When it is low, each of those outputs equals its stored bit.
- R7: A `loadStb` edge overwrites the chain with `statusIn`, using the same channel mapping as `chanOut`.
- R8: If `loadStb` and `shiftEn` are both high in one cycle, the load takes effect and no shift happens.
- R9: After a load, the 24 status bits appear on `serOut` one per shift, taken from the output end of the chain back to the input end. The selected group order sets which channels they are.
- R10: With `shiftEn` and `loadStb` both low, the chain keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shift clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| serIn | input | 1 | Serial data input |
| shiftEn | input | 1 | Shift the chain by one position |
| flowSel | input | 2 | Group order select |
| latchEn | input | 1 | Storage register follows the chain while high |
| loadStb | input | 1 | Parallel load of status into the chain |
| statusIn | input | 24 | Per-channel status word |
| grpEnN | input | 3 | Active-low enables for red, green and blue |
| chanOut | output | 24 | Gated channel drive bits |
| serOut | output | 1 | Last stage of the chain |

## Verification
The assertions check these rules on every cycle:
- the chain holds when it is idle;
- the storage holds while the latch input is low, and matches the chain while it is high;
- a load places the status word as given;
- the decoded order is always a permutation of the three groups.

Only the bench's scenarios can show that each flow-select code gives the right end-to-end placement of a shifted word. The same applies to the serial-out sequence of a loaded status word in each order, and to the 24-shift latency on the serial output.

// File: rtl/lsl_pkg.sv
package lsl_pkg;
  localparam int GRP_W = 8;
  localparam int N_GRP = 3;
  localparam int CHAIN_W = GRP_W * N_GRP;

  typedef enum logic [1:0] {
    COL_R = 2'd0,
    COL_G = 2'd1,
    COL_B = 2'd2
  } colour_t;

  typedef struct packed {
    logic    doLoad;
    logic    doShift;
    logic    doLatch;
    colour_t firstCol;
    colour_t midCol;
    colour_t lastCol;
  } lsl_strobe_t;
endpackage

// File: rtl/lsl_ctrl.sv
module lsl_ctrl
  import lsl_pkg::*;
(
  input  logic [1:0]  flowSel,
  input  logic        shiftEn,
  input  logic        loadStb,
  input  logic        latchEn,
  output lsl_strobe_t strobe
);
  colour_t firstCol, midCol, lastCol;

  always_comb begin
    unique case (flowSel)
      2'b01:   begin firstCol = COL_B; midCol = COL_R; lastCol = COL_G; end
      2'b10:   begin firstCol = COL_R; midCol = COL_G; lastCol = COL_B; end
      2'b00:   begin firstCol = COL_G; midCol = COL_R; lastCol = COL_B; end
      default: begin firstCol = COL_B; midCol = COL_G; lastCol = COL_R; end
    endcase
  end

  always_comb begin
    strobe.doLoad   = loadStb;
    strobe.doShift  = shiftEn & ~loadStb;  // load wins (R8)
    strobe.doLatch  = latchEn;
    strobe.firstCol = firstCol;
    strobe.midCol   = midCol;
    strobe.lastCol  = lastCol;
  end

  // R2: the decoded order must visit every group once
  always_comb begin
    assert_order_perm_R2: assert (strobe.firstCol != strobe.midCol &&
                                  strobe.midCol != strobe.lastCol &&
                                  strobe.firstCol != strobe.lastCol);
  end
endmodule

// File: rtl/lsl_datapath.sv
module lsl_datapath
  import lsl_pkg::*;
#(
  parameter int GW = GRP_W,
  parameter int NG = N_GRP,
  localparam int CW = GW * NG
) (
  input  logic          clk,
  input  logic          rstN,
  input  lsl_strobe_t   strobe,
  input  logic          serIn,
  input  logic [CW-1:0] statusIn,
  input  logic [NG-1:0] grpEnN,
  output logic [CW-1:0] chanOut,
  output logic          serOut
);
  logic [NG-1:0][GW-1:0] chain, chainNext, store;
  logic [NG-1:0]         srcBit;

  for (genvar c = 0; c < NG; c++) begin : g_grp
    always_comb begin
      if (c == int'(strobe.firstCol))    srcBit[c] = serIn;
      else if (c == int'(strobe.midCol)) srcBit[c] = chain[strobe.firstCol][GW-1];
      else                               srcBit[c] = chain[strobe.midCol][GW-1];
    end

    always_comb begin
      if (strobe.doLoad)       chainNext[c] = statusIn[c*GW +: GW];
      else if (strobe.doShift) chainNext[c] = {chain[c][GW-2:0], srcBit[c]};
      else                     chainNext[c] = chain[c];
    end

    assign chanOut[c*GW +: GW] = grpEnN[c] ? '0 : store[c];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chain <= '0;
      store <= '0;
    end else begin
      chain <= chainNext;
      if (strobe.doLatch) store <= chainNext;
    end
  end

  assign serOut = chain[strobe.lastCol][GW-1];

  assert_idle_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.doLoad && !strobe.doShift) |=> $stable(chain));
  assert_latch_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.doLatch |=> $stable(store));
  assert_latch_follow_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doLatch |=> (store == chain));
  assert_load_place_R7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.doLoad |=> (chain == $past(statusIn)));
endmodule

// File: rtl/led_shift_latch.sv
module led_shift_latch
  import lsl_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                serIn,
  input  logic                shiftEn,
  input  logic [1:0]          flowSel,
  input  logic                latchEn,
  input  logic                loadStb,
  input  logic [CHAIN_W-1:0]  statusIn,
  input  logic [N_GRP-1:0]    grpEnN,
  output logic [CHAIN_W-1:0]  chanOut,
  output logic                serOut
);
  lsl_strobe_t strobe;

  lsl_ctrl u_ctrl (
    .flowSel(flowSel),
    .shiftEn(shiftEn),
    .loadStb(loadStb),
    .latchEn(latchEn),
    .strobe (strobe)
  );

  lsl_datapath #(.GW(GRP_W), .NG(N_GRP)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strobe  (strobe),
    .serIn   (serIn),
    .statusIn(statusIn),
    .grpEnN  (grpEnN),
    .chanOut (chanOut),
    .serOut  (serOut)
  );
endmodule

// File: tb/led_shift_latch_tb.sv
module led_shift_latch_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic        serIn = 0, shiftEn = 0, latchEn = 0, loadStb = 0;
  logic [1:0]  flowSel = 2'b11;
  logic [23:0] statusIn = '0;
  logic [2:0]  grpEnN = 3'b000;
  logic [23:0] chanOut;
  logic        serOut;
  int          nChecks = 0, nFails = 0;

  always #2.5 clk = ~clk;

  led_shift_latch u_dut (.clk(clk), .rstN(rstN), .serIn(serIn), .shiftEn(shiftEn),
    .flowSel(flowSel), .latchEn(latchEn), .loadStb(loadStb), .statusIn(statusIn),
    .grpEnN(grpEnN), .chanOut(chanOut), .serOut(serOut));

  typedef struct packed {
    logic [1:0]  flow;
    logic [23:0] word;
    logic [2:0]  enN;
  } vec_t;
  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{2'b11, 24'hA5_3C_0F, 3'b000},
    '{2'b01, 24'h12_34_56, 3'b000},
    '{2'b10, 24'hFE_DC_BA, 3'b000},
    '{2'b00, 24'h81_42_24, 3'b000},
    '{2'b10, 24'hFF_FF_FF, 3'b101},
    '{2'b00, 24'h5A_C3_99, 3'b010}
  };

  // colour (0 R, 1 G, 2 B) at chain group k (0 = input end), per R2
  function automatic int orderCol(input logic [1:0] f, input int k);
    int t [3];
    case (f)
      2'b11: t = '{2, 1, 0};
      2'b01: t = '{2, 0, 1};
      2'b10: t = '{0, 1, 2};
      default: t = '{1, 0, 2};
    endcase
    return t[k];
  endfunction

  function automatic logic [23:0] placeWord(input logic [1:0] f, input logic [23:0] w);
    logic [23:0] r = '0;
    for (int k = 0; k < 3; k++) r[orderCol(f, k)*8 +: 8] = w[k*8 +: 8];
    return r;
  endfunction

  function automatic logic [23:0] enMask(input logic [2:0] e);
    logic [23:0] m;
    for (int g = 0; g < 3; g++) m[g*8 +: 8] = e[g] ? 8'h00 : 8'hFF;
    return m;
  endfunction

  task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(input logic sh, input logic d, input logic ld, input logic la);
    @(negedge clk);
    shiftEn = sh; serIn = d; loadStb = ld; latchEn = la;
    @(posedge clk); #1;
    shiftEn = 0; loadStb = 0; latchEn = 0;
  endtask

  task automatic shiftWord(input logic [23:0] w, input logic la);
    for (int i = 23; i >= 0; i--) tick(1, w[i], 0, la);
  endtask

  initial begin
    #100000;
    nFails++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 chanOut", chanOut, 24'h0);
    check("R1 serOut", {23'h0, serOut}, 24'h0);
    @(negedge clk); rstN = 1;

    // R2 / R6: table of orders and enable patterns
    for (int v = 0; v < NV; v++) begin
      flowSel = VECS[v].flow;
      grpEnN = 3'b000;
      shiftWord(VECS[v].word, 0);
      tick(0, 0, 0, 1);
      grpEnN = VECS[v].enN;
      #1;
      check("R2/R6 table", chanOut, placeWord(VECS[v].flow, VECS[v].word) & enMask(VECS[v].enN));
    end
    grpEnN = 3'b000;

    // R3: a bit reaches serOut after exactly 24 shifts
    flowSel = 2'b11;
    shiftWord(24'h000000, 0);
    tick(1, 1, 0, 0);
    for (int i = 0; i < 22; i++) tick(1, 0, 0, 0);
    check("R3 after 23", {23'h0, serOut}, 24'h0);
    tick(1, 0, 0, 0);
    check("R3 after 24", {23'h0, serOut}, 24'h1);

    // R5: storage holds while shifting with latch low
    flowSel = 2'b10;
    shiftWord(24'h13_57_9B, 0);
    tick(0, 0, 0, 1);
    shiftWord(24'hEC_A8_64, 0);
    check("R5 hold", chanOut, 24'h13_57_9B);

    // R4: latch held high follows the chain
    shiftWord(24'h0F_1E_2D, 1);
    check("R4 follow", chanOut, 24'h0F_1E_2D);
    tick(1, 1, 0, 1);
    check("R4 follow step", chanOut, {24'h0F_1E_2D} << 1 | 24'h1);

    // R10: idle chain holds
    shiftWord(24'h6B_2C_D7, 0);
    tick(0, 1, 0, 0); tick(0, 1, 0, 0); tick(0, 0, 0, 0);
    tick(0, 0, 0, 1);
    check("R10 idle", chanOut, 24'h6B_2C_D7);

    // R7 / R8: load wins over shift, channel mapping kept
    flowSel = 2'b01;
    statusIn = 24'hC3_7E_18;
    tick(1, 1, 1, 0);
    tick(0, 0, 0, 1);
    check("R7/R8 load", chanOut, 24'hC3_7E_18);

    // R9: status shifted out in each order
    for (int f = 0; f < 4; f++) begin
      logic [23:0] got, exp;
      flowSel = 2'(f);
      statusIn = 24'h9D_4A_E6 ^ {8'(f), 8'(f * 3), 8'(f * 5)};
      tick(0, 0, 1, 0);
      for (int k = 0; k < 24; k++) begin
        int p;
        p = 23 - k;
        got[k] = serOut;
        exp[k] = statusIn[orderCol(2'(f), p / 8) * 8 + p % 8];
        tick(1, 0, 0, 0);
      end
      check("R9 shift-out", got, exp);
    end

    // R1 again: reset mid-run clears storage
    @(negedge clk); rstN = 0; #1;
    check("R1 re-reset", chanOut, 24'h0);
    @(negedge clk); rstN = 1;

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule